// File: doc/BRIEF.md
# Dual-Clock Modal FIFO

This block is an 18-bit first-in first-out buffer that sits between a producer clocked by `wr_clk` and a consumer clocked by `rd_clk`. The storage depth is 2^AW words (4096 by default). Each write and read pointer crosses into the other clock domain as Gray code through a chain of synchronizing flops. Every status flag is registered in the domain of the clock that changes it. The full, almost-full and half-full flags belong to the write side. The empty/output-ready and almost-empty flags belong to the read side.

The output timing mode is taken from `fwft_sel` while master reset is held:

- **Standard mode (0):** a word reaches `dout` only when a read is requested.
- **Fall-through mode (1):** the oldest word is moved onto `dout` without any request, and a read request consumes it.

There are two resets. Master reset clears the pointers and the output register, and it latches the mode. Pointer reset clears the same state but keeps the latched mode. A rewind pulse sends the read pointer back to memory location zero so that stored data can be read a second time. The almost-full and almost-empty thresholds arrive on ports from an offset register block outside this one.

Top module: `dcfifo_modal`

## Requirements
- R1: While `master_rst_n` or `ptr_rst_n` is low, every read-clock edge sets `dout` to zero, and the almost-empty output low. Every write-clock edge sets `almost_full_n` and `half_full_n` high. Just after reset, standard mode shows `full_ir_n` high and `empty_or_n` low. Fall-through mode shows `full_ir_n` low and `empty_or_n` high.
- R2: `fwft_sel` is sampled on each clock edge while `master_rst_n` is low. A value of 1 selects fall-through mode and 0 selects standard mode. Outside master reset the level of `fwft_sel` has no effect.
- R3: A `ptr_rst_n` pulse empties the FIFO and zeroes `dout`. It leaves the latched mode unchanged.
- R4: In standard mode, each write-clock edge with `wr_en_n` low stores `din`, unless the FIFO is full. Each read-clock edge with `rd_en_n` low, while the FIFO is not empty, loads the oldest word into `dout`. Words come out in the order they were written. Otherwise `dout` holds.
- R5: In standard mode, `full_ir_n` goes low once 2^AW words are stored, and writes are then ignored.
- R6: In fall-through mode, the oldest word appears on `dout` with `empty_or_n` low and no read request. The word holds until a read-clock edge with `rd_en_n` low consumes it.
- R7: In fall-through mode, `full_ir_n` is low while the memory has a free location and high when it is full.
- R8: A read-clock edge with `rewind` high sets the read pointer to zero and leaves the write pointer and mode untouched. For the next cycle, `empty_or_n` is forced low in standard mode and high in fall-through mode. The next words delivered start at memory location zero.
- R9: `almost_full_n` is low when the write-side word count exceeds 2^AW minus `full_ofs`.
- R10: `almost_empty_n` is low when the read-side count of words left in memory is below `empty_ofs`. In fall-through mode this count excludes the word already on `dout`.
- R11: `half_full_n` is low when the write-side word count exceeds 2^(AW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| master_rst_n | input | 1 | Master reset, active low, synchronous in each domain; latches the mode |
| ptr_rst_n | input | 1 | Pointer reset, active low; keeps the mode |
| fwft_sel | input | 1 | Mode select, sampled during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| rewind | input | 1 | Read pointer rewind, read clock domain |
| full_ofs | input | AW+1 | Almost-full offset m |
| empty_ofs | input | AW+1 | Almost-empty offset n |
| dout | output | DW | Registered read data |
| full_ir_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| empty_or_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| almost_full_n | output | 1 | Programmable almost-full, active low |
| almost_empty_n | output | 1 | Programmable almost-empty, active low |
| half_full_n | output | 1 | More than half full, active low |

## Verification
The bound checker watches several properties on every cycle:

- the latched mode does not move outside master reset;
- `dout` stays still in standard mode whenever no read is taken;
- a valid fall-through word holds until it is consumed;
- the flag a rewind forces takes its mode-dependent value;
- full implies almost-full, and almost-full above the half-way point implies half-full.

Some behaviour can only be shown by the bench scenarios against its queue-free reference model:

- word ordering;
- the exact count boundaries of the three threshold flags;
- the values the two resets leave behind;
- the mode surviving a pointer reset;
- the replay from location zero.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } out_mode_e;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   // Each binary bit is the XOR of all Gray bits at and above it.
   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      for (int i = 0; i < 32; i++) begin
         b[i] = ^(g >> i);
      end
      return b;
   endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
   parameter int W      = 13,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dcfifo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
   parameter int DW = 18,
   parameter int AW = 12
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int WORDS = 1 << AW;

   logic [DW-1:0] cells [WORDS];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
   import dcfifo_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en_n,
   input  logic [AW:0]   rgray_s,
   input  logic [AW:0]   full_ofs,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          full,
   output logic          paf_n,
   output logic          hf_n
);

   localparam int              PW      = AW + 1;
   localparam logic [PW-1:0]   DEPTH_V = {1'b1, {AW{1'b0}}};
   localparam logic [PW-1:0]   HALF_V  = {2'b01, {(AW-1){1'b0}}};

   logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx;

   assign we      = !wr_en_n && !full;
   assign wbin_nx = wbin + PW'(we);
   assign rbin_s  = PW'(gray2bin(32'(rgray_s)));
   assign used_nx = wbin_nx - rbin_s;
   assign waddr   = wbin[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         wbin  <= '0;
         wgray <= '0;
         full  <= 1'b0;
         paf_n <= 1'b1;
         hf_n  <= 1'b1;
      end else begin
         wbin  <= wbin_nx;
         wgray <= PW'(bin2gray(32'(wbin_nx)));
         full  <= (used_nx == DEPTH_V);
         paf_n <= !(used_nx > (DEPTH_V - full_ofs));
         hf_n  <= !(used_nx > HALF_V);
      end
   end

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
   import dcfifo_pkg::*;
#(
   parameter int DW = 18,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  out_mode_e     mode,
   input  logic          rd_en_n,
   input  logic          rewind,
   input  logic [AW:0]   wgray_s,
   input  logic [AW:0]   empty_ofs,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          empty_or_n,
   output logic          pae_n
);

   localparam int PW = AW + 1;

   logic [PW-1:0] rbin, rbin_nx, wbin_s, avail_nx;
   logic          mem_empty;
   logic          out_valid;
   logic          take;

   assign wbin_s = PW'(gray2bin(32'(wgray_s)));
   assign raddr  = rbin[AW-1:0];

   // Fall-through refills the output stage whenever it is free or being drained.
   always_comb begin
      if (mode == MODE_FWFT) take = !mem_empty && (!out_valid || !rd_en_n);
      else                   take = !mem_empty && !rd_en_n;
   end

   assign rbin_nx  = rewind ? '0 : rbin + PW'(take);
   assign avail_nx = wbin_s - rbin_nx;

   always_ff @(posedge clk) begin
      if (rst) begin
         rbin      <= '0;
         rgray     <= '0;
         mem_empty <= 1'b1;
         out_valid <= 1'b0;
         dout      <= '0;
         pae_n     <= 1'b0;
      end else begin
         rbin      <= rbin_nx;
         rgray     <= PW'(bin2gray(32'(rbin_nx)));
         mem_empty <= rewind ? 1'b1 : (avail_nx == '0);
         pae_n     <= !(avail_nx < empty_ofs);
         if (rewind) begin
            out_valid <= 1'b0;
         end else if (take) begin
            dout      <= rdata;
            out_valid <= 1'b1;
         end else if (!rd_en_n) begin
            out_valid <= 1'b0;
         end
      end
   end

   assign empty_or_n = (mode == MODE_FWFT) ? !out_valid : !mem_empty;

endmodule

// File: rtl/dcfifo_modal.sv
module dcfifo_modal
   import dcfifo_pkg::*;
#(
   parameter int DW          = 18,
   parameter int AW          = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          master_rst_n,
   input  logic          ptr_rst_n,
   input  logic          fwft_sel,
   input  logic          wr_en_n,
   input  logic [DW-1:0] din,
   input  logic          rd_en_n,
   input  logic          rewind,
   input  logic [AW:0]   full_ofs,
   input  logic [AW:0]   empty_ofs,
   output logic [DW-1:0] dout,
   output logic          full_ir_n,
   output logic          empty_or_n,
   output logic          almost_full_n,
   output logic          almost_empty_n,
   output logic          half_full_n
);

   localparam int PW = AW + 1;

   if (DW < 1) begin : g_bad_dw
      $error("dcfifo_modal: DW must be positive");
   end
   if (AW < 2 || AW > 30) begin : g_bad_aw
      $error("dcfifo_modal: AW must lie in 2..30");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcfifo_modal: SYNC_STAGES must be at least 2");
   end

   logic          clr;
   out_mode_e     wr_mode, rd_mode;
   logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
   logic          we, wr_full;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] rdata;

   assign clr = !master_rst_n || !ptr_rst_n;

   always_ff @(posedge wr_clk) begin
      if (!master_rst_n) wr_mode <= out_mode_e'(fwft_sel);
   end

   always_ff @(posedge rd_clk) begin
      if (!master_rst_n) rd_mode <= out_mode_e'(fwft_sel);
   end

   dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk (wr_clk),
      .rst (clr),
      .d   (rgray),
      .q   (rgray_ws)
   );

   dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk (rd_clk),
      .rst (clr),
      .d   (wgray),
      .q   (wgray_rs)
   );

   dcfifo_wr_ctl #(.AW(AW)) u_wr (
      .clk      (wr_clk),
      .rst      (clr),
      .wr_en_n  (wr_en_n),
      .rgray_s  (rgray_ws),
      .full_ofs (full_ofs),
      .we       (we),
      .waddr    (waddr),
      .wgray    (wgray),
      .full     (wr_full),
      .paf_n    (almost_full_n),
      .hf_n     (half_full_n)
   );

   dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk  (wr_clk),
      .we    (we),
      .waddr (waddr),
      .wdata (din),
      .raddr (raddr),
      .rdata (rdata)
   );

   dcfifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
      .clk        (rd_clk),
      .rst        (clr),
      .mode       (rd_mode),
      .rd_en_n    (rd_en_n),
      .rewind     (rewind),
      .wgray_s    (wgray_rs),
      .empty_ofs  (empty_ofs),
      .rdata      (rdata),
      .raddr      (raddr),
      .rgray      (rgray),
      .dout       (dout),
      .empty_or_n (empty_or_n),
      .pae_n      (almost_empty_n)
   );

   assign full_ir_n = (wr_mode == MODE_FWFT) ? wr_full : !wr_full;

endmodule

// File: rtl/dcfifo_modal_chk.sv
module dcfifo_modal_chk
   import dcfifo_pkg::*;
#(
   parameter int DW = 18,
   parameter int AW = 12
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          master_rst_n,
   input logic          ptr_rst_n,
   input logic          rd_en_n,
   input logic          rewind,
   input logic [AW:0]   full_ofs,
   input logic [DW-1:0] dout,
   input logic          full_ir_n,
   input logic          empty_or_n,
   input logic          almost_full_n,
   input logic          half_full_n,
   input out_mode_e     rd_mode,
   input out_mode_e     wr_mode
);

   localparam logic [AW:0] HALF_V = {2'b01, {(AW-1){1'b0}}};

   logic any_rst;
   assign any_rst = !master_rst_n || !ptr_rst_n;

   // R2 and R3: the latched mode moves only under master reset.
   p_mode_hold_r2: assert property (@(posedge rd_clk) disable iff (!master_rst_n)
      master_rst_n |=> $stable(rd_mode));

   p_wmode_hold_r3: assert property (@(posedge wr_clk) disable iff (!master_rst_n)
      master_rst_n |=> $stable(wr_mode));

   p_std_hold_r4: assert property (@(posedge rd_clk) disable iff (any_rst)
      (rd_mode == MODE_STD && (rd_en_n || rewind)) |=> $stable(dout));

   p_fwft_hold_r6: assert property (@(posedge rd_clk) disable iff (any_rst)
      (rd_mode == MODE_FWFT && !empty_or_n && rd_en_n && !rewind)
      |=> (!empty_or_n && $stable(dout)));

   p_rewind_flag_r8: assert property (@(posedge rd_clk) disable iff (any_rst)
      rewind |=> ((rd_mode == MODE_FWFT) ? empty_or_n : !empty_or_n));

   p_full_paf_r9: assert property (@(posedge wr_clk) disable iff (any_rst)
      (wr_mode == MODE_STD && !full_ir_n && full_ofs != '0) |-> !almost_full_n);

   p_paf_hf_r11: assert property (@(posedge wr_clk) disable iff (any_rst)
      (full_ofs < HALF_V && !almost_full_n) |-> !half_full_n);

endmodule

bind dcfifo_modal dcfifo_modal_chk #(.DW(DW), .AW(AW)) chk_i (
   .wr_clk        (wr_clk),
   .rd_clk        (rd_clk),
   .master_rst_n  (master_rst_n),
   .ptr_rst_n     (ptr_rst_n),
   .rd_en_n       (rd_en_n),
   .rewind        (rewind),
   .full_ofs      (full_ofs),
   .dout          (dout),
   .full_ir_n     (full_ir_n),
   .empty_or_n    (empty_or_n),
   .almost_full_n (almost_full_n),
   .half_full_n   (half_full_n),
   .rd_mode       (rd_mode),
   .wr_mode       (wr_mode)
);

// File: tb/dcfifo_modal_tb_top.sv
module dcfifo_modal_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 18;
   localparam int AW = 4;
   localparam int D  = 1 << AW;

   logic          clk = 1'b0;
   logic          master_rst_n = 1'b0, ptr_rst_n = 1'b1, fwft_sel = 1'b0;
   logic          wr_en_n = 1'b1, rd_en_n = 1'b1, rewind = 1'b0;
   logic [DW-1:0] din = '0;
   logic [AW:0]   full_ofs = 5'd3, empty_ofs = 5'd2;
   logic [DW-1:0] dout;
   logic          full_ir_n, empty_or_n, almost_full_n, almost_empty_n, half_full_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcfifo_modal #(.DW(DW), .AW(AW)) dut_i (
      .wr_clk(clk), .rd_clk(clk), .master_rst_n(master_rst_n), .ptr_rst_n(ptr_rst_n),
      .fwft_sel(fwft_sel), .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n),
      .rewind(rewind), .full_ofs(full_ofs), .empty_ofs(empty_ofs), .dout(dout),
      .full_ir_n(full_ir_n), .empty_or_n(empty_or_n), .almost_full_n(almost_full_n),
      .almost_empty_n(almost_empty_n), .half_full_n(half_full_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: unbounded write/read counts, two-cycle delayed views.
   int            mW, mR, wq1, wq2, rq1, rq2;
   bit            mfull, mempty, mov, mfwft;
   bit            mpaf_n, mhf_n, mpae_n;
   logic [DW-1:0] mdout;
   logic [DW-1:0] mmem [D];

   always @(posedge clk) begin : mdl
      int wn, rn, used, avail;
      bit we, take;
      if (!master_rst_n) mfwft = fwft_sel;
      if (!master_rst_n || !ptr_rst_n) begin
         mW = 0; mR = 0; wq1 = 0; wq2 = 0; rq1 = 0; rq2 = 0;
         mfull = 0; mempty = 1; mov = 0; mdout = '0;
         mpaf_n = 1; mhf_n = 1; mpae_n = 0;
      end else begin
         we   = !wr_en_n && !mfull;
         wn   = mW + int'(we);
         used = wn - rq2;
         if (mfwft) take = !mempty && (!mov || !rd_en_n);
         else       take = !mempty && !rd_en_n;
         rn    = rewind ? 0 : mR + int'(take);
         avail = wq2 - rn;
         if (rewind) mov = 0;
         else if (take) begin mdout = mmem[mR % D]; mov = 1; end
         else if (!rd_en_n) mov = 0;
         if (we) mmem[mW % D] = din;
         mfull  = (used == D);
         mpaf_n = !(used > D - int'(full_ofs));
         mhf_n  = !(used > D / 2);
         mempty = rewind ? 1'b1 : (avail == 0);
         mpae_n = !(avail < int'(empty_ofs));
         rq2 = rq1; rq1 = mR; wq2 = wq1; wq1 = mW;
         mW = wn; mR = rn;
      end
   end

   always @(posedge clk) begin
      #3;
      if (!done) begin
         chk("R4 dout vs model", 32'(dout), 32'(mdout));
         chk(mfwft ? "R7 full_ir_n vs model" : "R5 full_ir_n vs model",
             32'(full_ir_n), 32'(mfwft ? mfull : !mfull));
         chk(mfwft ? "R6 empty_or_n vs model" : "R8 empty_or_n vs model",
             32'(empty_or_n), 32'(mfwft ? !mov : !mempty));
         chk("R9 almost_full_n vs model", 32'(almost_full_n), 32'(mpaf_n));
         chk("R10 almost_empty_n vs model", 32'(almost_empty_n), 32'(mpae_n));
         chk("R11 half_full_n vs model", 32'(half_full_n), 32'(mhf_n));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_burst(input int n, input logic [DW-1:0] base);
      for (int i = 0; i < n; i++) begin
         wr_en_n = 1'b0;
         din     = base + DW'(i);
         @(negedge clk);
      end
      wr_en_n = 1'b1;
   endtask

   task automatic rd_burst(input int n);
      for (int i = 0; i < n; i++) begin
         rd_en_n = 1'b0;
         @(negedge clk);
      end
      rd_en_n = 1'b1;
   endtask

   task automatic pulse_rewind();
      rewind = 1'b1;
      @(negedge clk);
      rewind = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // Master reset, standard mode.
      @(negedge clk);
      idle(3);
      master_rst_n = 1'b1;
      chk("R1 dout after master reset", 32'(dout), 0);
      chk("R1 empty_or_n std", 32'(empty_or_n), 0);
      chk("R1 full_ir_n std", 32'(full_ir_n), 1);
      chk("R1 almost_full_n", 32'(almost_full_n), 1);
      chk("R1 half_full_n", 32'(half_full_n), 1);
      chk("R1 almost_empty_n", 32'(almost_empty_n), 0);

      // Mode select outside reset is ignored: no fall-through.
      fwft_sel = 1'b1;
      wr_burst(5, 18'h100);
      idle(5);
      chk("R2 no fall-through in std", 32'(dout), 0);
      chk("R2 not empty", 32'(empty_or_n), 1);
      chk("R10 five left not almost empty", 32'(almost_empty_n), 1);
      rd_burst(4);
      idle(2);
      chk("R4 fourth word in order", 32'(dout), 32'h103);
      chk("R10 one left almost empty", 32'(almost_empty_n), 0);
      rd_burst(1);
      idle(3);
      chk("R4 fifth word", 32'(dout), 32'h104);
      chk("R4 empty after drain", 32'(empty_or_n), 0);

      // Fill past capacity.
      wr_burst(20, 18'h200);
      idle(4);
      chk("R5 full at capacity", 32'(full_ir_n), 0);
      chk("R9 almost full at 16", 32'(almost_full_n), 0);
      chk("R11 half full at 16", 32'(half_full_n), 0);
      rd_burst(3);
      idle(5);
      chk("R9 13 words not above 13", 32'(almost_full_n), 1);
      chk("R11 13 words above half", 32'(half_full_n), 0);
      chk("R5 no longer full", 32'(full_ir_n), 1);
      rd_burst(5);
      idle(5);
      chk("R11 8 words not above half", 32'(half_full_n), 1);
      rd_burst(10);
      idle(3);
      chk("R5 extra writes dropped", 32'(dout), 32'h20F);

      // Pointer reset keeps standard mode.
      ptr_rst_n = 1'b0;
      idle(2);
      ptr_rst_n = 1'b1;
      idle(1);
      chk("R3 dout zero after pointer reset", 32'(dout), 0);
      wr_burst(1, 18'h300);
      idle(6);
      chk("R3 std mode kept", 32'(dout), 0);
      rd_burst(1);
      idle(2);

      // Rewind in standard mode.
      wr_burst(3, 18'h310);
      idle(5);
      rd_burst(2);
      idle(1);
      chk("R4 read after pointer reset", 32'(dout), 32'h311);
      pulse_rewind();
      chk("R8 empty forced low std", 32'(empty_or_n), 0);
      idle(4);
      rd_burst(1);
      idle(2);
      chk("R8 replay from location zero", 32'(dout), 32'h300);
      rd_burst(1);
      idle(2);
      chk("R8 replay second word", 32'(dout), 32'h310);
      rd_burst(5);
      idle(2);

      // Master reset into fall-through mode.
      master_rst_n = 1'b0;
      idle(3);
      master_rst_n = 1'b1;
      fwft_sel = 1'b0;
      chk("R1 output-ready high in fwft", 32'(empty_or_n), 1);
      chk("R7 input ready after reset", 32'(full_ir_n), 0);
      wr_burst(1, 18'h400);
      idle(6);
      chk("R6 word falls through", 32'(dout), 32'h400);
      chk("R6 output ready", 32'(empty_or_n), 0);
      rd_burst(1);
      idle(6);
      chk("R6 consumed", 32'(empty_or_n), 1);
      wr_burst(20, 18'h410);
      idle(6);
      chk("R7 not ready when full", 32'(full_ir_n), 1);
      rd_burst(25);
      idle(4);
      chk("R6 drained", 32'(empty_or_n), 1);

      // Pointer reset keeps fall-through mode.
      ptr_rst_n = 1'b0;
      idle(2);
      ptr_rst_n = 1'b1;
      idle(1);
      chk("R3 fwft output-ready high", 32'(empty_or_n), 1);
      wr_burst(1, 18'h500);
      idle(6);
      chk("R3 fwft mode kept", 32'(dout), 32'h500);

      // Rewind in fall-through mode.
      wr_burst(2, 18'h510);
      idle(5);
      rd_burst(1);
      idle(5);
      chk("R6 next word loads", 32'(dout), 32'h510);
      pulse_rewind();
      chk("R8 output-ready forced high", 32'(empty_or_n), 1);
      idle(6);
      chk("R8 fwft replay location zero", 32'(dout), 32'h500);
      chk("R8 fwft ready again", 32'(empty_or_n), 0);

      idle(2);
      finish_run();
   end

endmodule